// File: doc/BRIEF.md
# Bubble-Free Synchronous SRAM with Flow-Through Reads

This block is a clocked single-port memory of 256 words by 36 bits. It accepts a new read or write on every enabled clock edge, and a bus that switches between reading and writing never needs an idle cycle. A read is flow-through: the word for an address latched on one edge comes out during the clock period that follows that edge. A write is late: its address and direction are latched on one edge, and its data and byte enables are taken on the next enabled edge. A write data phase therefore lines up with the following operation's address phase.

A load cycle latches an external address. After that, an advance cycle steps through a four-word group on the two low address bits, in linear or interleaved order, and wraps back to the start. A clock-enable input freezes all state. An asynchronous output enable gates the read data. A sleep request shuts the block down after a fixed delay and releases it after a fixed wake-up delay. The array contents are kept during sleep.

Top module: `nobubble_sram`

## Requirements
- R1: After reset, and with no operation in progress, `dout_vld` is 0 and `dout` is all zeros.
- R2: A load cycle needs `cke_n`=0, `adv_ld`=0, `ce1_n`=0, `ce2`=1 and `ce3_n`=0 on a clock edge. With `we_n`=1 it is a read: during the period after that edge, `dout_vld`=1 and `dout` holds the word at the latched address, provided `oe_n` is 0.
- R3: When `adv_ld`=0 and `cke_n`=0 but any one chip enable is inactive, the edge deselects the block: `dout_vld` is 0 and `dout` is zero during the following period.
- R4: A load with `we_n`=0 starts a write. On the next enabled edge, each byte lane i (bits 9i+8 down to 9i) of `din` is written to the latched address when `bwe_n[i]`=0. Lanes with `bwe_n[i]`=1 keep their old contents.
- R5: A read loaded on the same edge that completes a write to that address returns the newly written data. Reads and writes may alternate on consecutive edges with no idle cycle.
- R6: With `seq_il`=0, each enabled edge with `adv_ld`=1 during an active burst moves the two low address bits to (start + n) mod 4, where n counts advances since the load. The upper bits stay fixed, and the group wraps after four words.
- R7: With `seq_il`=1, the advance order instead uses start XOR n.
- R8: After a deselect, `adv_ld`=1 starts no burst, and the output stays disabled until a new load.
- R9: When `oe_n`=1, `dout_vld` is 0 and `dout` is zero within the same cycle, with no clock edge needed. Clearing `oe_n` restores the read data.
- R10: While `cke_n`=1, edges change nothing: no address advance, no load, and no write completion. A write waiting for its data completes on the next enabled edge instead.
- R11: `sleep` is sampled on every edge. The two edges after it is first seen high still operate normally, and the output turns off after the second one. While asleep, and for the two edges after `sleep` is first seen low, no operation happens, the array is unchanged and the output is off. The array contents survive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of control state |
| cke_n | input | 1 | Clock enable, active low |
| adv_ld | input | 1 | 1 = advance burst, 0 = load new address or deselect |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | 0 = write, 1 = read, taken on load |
| bwe_n | input | 4 | Byte lane write enables, active low, taken with write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| seq_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Sleep request |
| addr | input | 8 | Word address |
| din | input | 36 | Write data |
| dout | output | 36 | Read data, zero when not driven |
| dout_vld | output | 1 | High while `dout` carries read data |

## Verification
Read data for an operation latched on edge k is due in the period after edge k. Write data goes in one cycle later, on edge k+1, so reading it back is possible after edge k+1 at the earliest. The bench drives its inputs 1 ns after each rising edge and compares the outputs 1 ns after the next rising edge, so every comparison sees exactly one new edge. The output enable is checked 1 ns after it toggles, with no edge in between. For sleep, the checks fall after the second edge following assertion, and after the second edge following release, to pin both delays.

// File: rtl/nobubble_sram.sv
module nobubble_sram #(
  parameter int AW = 8,
  parameter int DW = 36,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke_n,
  input  logic          adv_ld,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          ce3_n,
  input  logic          we_n,
  input  logic [NB-1:0] bwe_n,
  input  logic          oe_n,
  input  logic          seq_il,
  input  logic          sleep,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_vld
);
  localparam int BW    = DW / NB;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          active, cur_wr, s1, s2;
  logic [AW-1:0] cur_addr;
  logic [1:0]    base, cnt;

  wire       sel     = ~ce1_n & ce2 & ~ce3_n;
  wire       go      = ~cke_n & ~s2;
  wire [1:0] nxt_cnt = cnt + 2'd1;
  wire [1:0] nxt_lo  = seq_il ? (base ^ nxt_cnt) : (base + nxt_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= sleep;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cur_wr   <= 1'b0;
      cur_addr <= '0;
      base     <= '0;
      cnt      <= '0;
    end else if (!cke_n) begin
      if (s2) begin
        active <= 1'b0;
      end else if (!adv_ld) begin
        active <= sel;
        if (sel) begin
          cur_addr <= addr;
          base     <= addr[1:0];
          cnt      <= '0;
          cur_wr   <= ~we_n;
        end
      end else if (active) begin
        cnt           <= nxt_cnt;
        cur_addr[1:0] <= nxt_lo;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && go && active && cur_wr) begin
      for (int b = 0; b < NB; b++) begin
        if (!bwe_n[b]) mem[cur_addr][b*BW +: BW] <= din[b*BW +: BW];
      end
    end
  end

  assign dout_vld = active & ~cur_wr & ~oe_n & ~s2;
  assign dout     = dout_vld ? mem[cur_addr] : '0;
endmodule

module nobubble_sram_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cke_n,
  input logic          adv_ld,
  input logic          ce1_n,
  input logic          ce2,
  input logic          ce3_n,
  input logic          seq_il,
  input logic          sleep,
  input logic          active,
  input logic          s2,
  input logic [AW-1:0] cur_addr,
  input logic          dout_vld
);
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv_ld && !(!ce1_n && ce2 && !ce3_n)) |=> !dout_vld); // R3

  AST_IDLE_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && adv_ld) |=> !active); // R8

  AST_CKE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(cur_addr) && $stable(active))); // R10

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && adv_ld && !cke_n && !s2 && !seq_il)
      |=> (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1) &&
          (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2]))); // R6

  AST_SLEEP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sleep, 2) |-> !dout_vld); // R11
endmodule

bind nobubble_sram nobubble_sram_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv_ld(adv_ld),
  .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .seq_il(seq_il), .sleep(sleep),
  .active(active), .s2(s2), .cur_addr(cur_addr), .dout_vld(dout_vld)
);

// File: tb/sim_nobubble_sram.sv
`timescale 1ns/1ps
module sim_nobubble_sram;
  logic        clk = 1'b0;
  logic        rst_n, cke_n, adv_ld, ce1_n, ce2, ce3_n, we_n, oe_n, seq_il, sleep;
  logic [3:0]  bwe_n;
  logic [7:0]  addr;
  logic [35:0] din, dout;
  logic        dout_vld;
  int          n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  nobubble_sram u0 (.clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv_ld(adv_ld),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n), .bwe_n(bwe_n),
    .oe_n(oe_n), .seq_il(seq_il), .sleep(sleep), .addr(addr), .din(din),
    .dout(dout), .dout_vld(dout_vld));

  localparam logic [35:0] D0 = 36'h1A5A5A5A5;
  localparam logic [35:0] D1 = 36'h2C3C3C3C3;
  localparam logic [35:0] D2 = 36'h3F0F0F0F0;
  localparam logic [35:0] D3 = 36'h488887777;
  localparam logic [35:0] D4 = 36'h5DEADBEEF;
  localparam logic [35:0] D5 = 36'h6BADC0DE1;
  localparam logic [35:0] MG = (D2 & 36'hFFFFC0000) | (D4 & 36'h00003FFFF);

  typedef struct packed {
    logic        adv;
    logic        wen;
    logic [2:0]  ces;
    logic [7:0]  a;
    logic [35:0] d;
    logic [3:0]  bw;
    logic        ev;
    logic [35:0] ed;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b0, 3'b010, 8'h10, 36'h0, 4'hF, 1'b0, 36'h0},
    '{1'b0, 1'b0, 3'b010, 8'h11, D0,    4'h0, 1'b0, 36'h0},
    '{1'b0, 1'b0, 3'b010, 8'h12, D1,    4'h0, 1'b0, 36'h0},
    '{1'b0, 1'b0, 3'b010, 8'h13, D2,    4'h0, 1'b0, 36'h0},
    '{1'b0, 1'b1, 3'b010, 8'h10, D3,    4'h0, 1'b1, D0},
    '{1'b0, 1'b1, 3'b010, 8'h13, 36'h0, 4'hF, 1'b1, D3},
    '{1'b0, 1'b0, 3'b010, 8'h12, 36'h0, 4'hF, 1'b0, 36'h0},
    '{1'b0, 1'b1, 3'b010, 8'h12, D4,    4'hC, 1'b1, MG},
    '{1'b1, 1'b1, 3'b010, 8'h00, 36'h0, 4'hF, 1'b1, D3},
    '{1'b1, 1'b1, 3'b010, 8'h00, 36'h0, 4'hF, 1'b1, D0},
    '{1'b1, 1'b1, 3'b010, 8'h00, 36'h0, 4'hF, 1'b1, D1},
    '{1'b1, 1'b1, 3'b010, 8'h00, 36'h0, 4'hF, 1'b1, MG},
    '{1'b0, 1'b1, 3'b111, 8'h00, 36'h0, 4'hF, 1'b0, 36'h0},
    '{1'b1, 1'b1, 3'b010, 8'h00, 36'h0, 4'hF, 1'b0, 36'h0},
    '{1'b0, 1'b1, 3'b010, 8'h11, 36'h0, 4'hF, 1'b1, D1}
  };

  task automatic chk(input string req, input logic ev, input logic [35:0] ed);
    n_cmp++;
    if (dout_vld !== ev || dout !== ed) begin
      n_bad++;
      $display("FAIL %s: got vld=%b dout=%h, expected vld=%b dout=%h",
               req, dout_vld, dout, ev, ed);
    end
  endtask

  task automatic op(input logic adv, input logic wen, input logic [2:0] ces,
                    input logic [7:0] a, input logic [35:0] d, input logic [3:0] bw);
    adv_ld = adv; we_n = wen; {ce1_n, ce2, ce3_n} = ces;
    addr = a; din = d; bwe_n = bw;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cke_n = 1'b0; adv_ld = 1'b0; ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1;
    we_n = 1'b1; bwe_n = 4'hF; oe_n = 1'b0; seq_il = 1'b0; sleep = 1'b0;
    addr = '0; din = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R1 reset", 1'b0, 36'h0);

    // Table: R2 R4 R5 R6 R3 R8
    for (int i = 0; i < NV; i++) begin
      op(TBL[i].adv, TBL[i].wen, TBL[i].ces, TBL[i].a, TBL[i].d, TBL[i].bw);
      chk($sformatf("R2/R4/R5/R6/R3/R8 row %0d", i), TBL[i].ev, TBL[i].ed);
    end

    // R9 asynchronous output enable
    op(1'b0, 1'b1, 3'b010, 8'h10, 36'h0, 4'hF);
    chk("R9 read", 1'b1, D0);
    oe_n = 1'b1; #1;
    chk("R9 oe high", 1'b0, 36'h0);
    oe_n = 1'b0; #1;
    chk("R9 oe low", 1'b1, D0);

    // R10 clock enable freeze and deferred write
    cke_n = 1'b1;
    op(1'b1, 1'b1, 3'b010, 8'h00, 36'h0, 4'hF);
    chk("R10 no advance", 1'b1, D0);
    op(1'b0, 1'b0, 3'b010, 8'h20, 36'h0, 4'hF);
    chk("R10 no load", 1'b1, D0);
    cke_n = 1'b0;
    op(1'b0, 1'b0, 3'b010, 8'h20, 36'h0, 4'hF);
    chk("R10 write loaded", 1'b0, 36'h0);
    cke_n = 1'b1;
    op(1'b0, 1'b1, 3'b010, 8'h30, 36'hFFFFFFFFF, 4'h0);
    chk("R10 write held", 1'b0, 36'h0);
    cke_n = 1'b0;
    op(1'b0, 1'b1, 3'b010, 8'h20, D5, 4'h0);
    chk("R10 deferred write data", 1'b1, D5);

    // R3 each chip enable alone
    op(1'b0, 1'b1, 3'b000, 8'h10, 36'h0, 4'hF);
    chk("R3 ce2 low", 1'b0, 36'h0);
    op(1'b0, 1'b1, 3'b011, 8'h10, 36'h0, 4'hF);
    chk("R3 ce3_n high", 1'b0, 36'h0);
    op(1'b0, 1'b1, 3'b110, 8'h10, 36'h0, 4'hF);
    chk("R3 ce1_n high", 1'b0, 36'h0);

    // R7 interleaved order from start 1: 1,0,3,2,1
    seq_il = 1'b1;
    op(1'b0, 1'b1, 3'b010, 8'h11, 36'h0, 4'hF);
    chk("R7 start", 1'b1, D1);
    op(1'b1, 1'b1, 3'b010, 8'h00, 36'h0, 4'hF);
    chk("R7 step1", 1'b1, D0);
    op(1'b1, 1'b1, 3'b010, 8'h00, 36'h0, 4'hF);
    chk("R7 step2", 1'b1, D3);
    op(1'b1, 1'b1, 3'b010, 8'h00, 36'h0, 4'hF);
    chk("R7 step3", 1'b1, MG);
    op(1'b1, 1'b1, 3'b010, 8'h00, 36'h0, 4'hF);
    chk("R7 wrap", 1'b1, D1);
    seq_il = 1'b0;

    // R11 sleep entry, blocked operations, wake-up
    sleep = 1'b1;
    op(1'b0, 1'b1, 3'b010, 8'h11, 36'h0, 4'hF);
    chk("R11 first edge normal", 1'b1, D1);
    op(1'b0, 1'b1, 3'b010, 8'h13, 36'h0, 4'hF);
    chk("R11 asleep after two", 1'b0, 36'h0);
    op(1'b0, 1'b0, 3'b010, 8'h11, 36'h0, 4'hF);
    chk("R11 write blocked", 1'b0, 36'h0);
    sleep = 1'b0;
    op(1'b0, 1'b0, 3'b010, 8'h13, 36'h0, 4'h0);
    chk("R11 wake edge 1", 1'b0, 36'h0);
    op(1'b0, 1'b1, 3'b010, 8'h12, 36'h0, 4'h0);
    chk("R11 wake edge 2", 1'b0, 36'h0);
    op(1'b0, 1'b1, 3'b010, 8'h11, 36'h0, 4'hF);
    chk("R11 contents kept 0x11", 1'b1, D1);
    op(1'b0, 1'b1, 3'b010, 8'h13, 36'h0, 4'hF);
    chk("R11 contents kept 0x13", 1'b1, D3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule